// File: doc/BRIEF.md
# DMA Coalescing Controller

This block sits between the per-port receive buffers of a four-port network receive path and the host-facing DMA engine and interrupt lines. It decides when buffered packet data may be moved to host memory. While it is coalescing, every DMA grant and every interrupt is held back, and packet data stays on chip. Coalescing ends when either of two things happens. The first is that the bytes held across all ports together reach a programmable watermark. The second is that a programmable timer, which starts with the first packet after a burst, runs out. The controller then opens one burst window in which all ports are released at the same time.

Inside the burst window, interrupts also pass through a shared moderation throttle. After any interrupt is released, all interrupt outputs stay quiet for a set number of clock cycles. The window closes once every port reports an empty buffer. The controller then goes back to waiting, with its timer cleared.

When the timer setting is zero or interrupt moderation is switched off, the block is transparent: grants and interrupts follow their requests in the same cycle. That is also the state after reset. The interfaces here are plain request/grant and level signals with no back-pressure. A port holds `dma_req` until its buffer drains, and the grant is a same-cycle qualifier on that request.

Top module: `dcoal_ctrl`

## Requirements
- R1: After reset the timer code is 0 and moderation is off, `stat_state` reads 0 (idle) and `stat_cause` reads 0 (none).
- R2: When the block is disabled (timer code 0 or moderation enable 0), `dma_gnt` equals `dma_req` and `irq_out` equals `irq_req` in every cycle, whatever the buffer levels are. The state stays idle.
- R3: When the block is enabled and the state is idle (0) or coalescing (1), `dma_gnt` and `irq_out` are all zero.
- R4: When the block is enabled and idle, a cycle in which some buffer level is non-zero and the summed level is below the watermark moves the state to coalescing (1) at the next edge. The coalescing timer starts from zero there.
- R5: When the block is enabled and idle or coalescing, a cycle in which the summed level is non-zero and at least the watermark moves the state to burst (2) with `stat_cause` 1 (watermark) at the next edge. If the watermark and timer expiry land in the same cycle, the watermark is the cause reported.
- R6: If the watermark is not reached, the coalescing state lasts exactly limit × CLK_PER_US cycles. The state then becomes burst (2) with `stat_cause` 2 (timer).
- R7: The timer code maps to a limit in microseconds as follows: 1→250, 2→500, codes 3 to 12 → (code−2)×1000, and codes 13 to 15 → 10000. Code 0 disables the block.
- R8: In the burst state, `dma_gnt` equals `dma_req` on all ports together.
- R9: In the burst state, a cycle with every buffer level zero returns the state to idle (0) at the next edge. The next coalescing period times from zero again.
- R10: In the burst state, `irq_out` is `irq_req` masked by a shared throttle. After any cycle in which some interrupt is released, all `irq_out` bits stay zero for the next `gap` cycles, where `gap` is the programmed interrupt gap. A gap of 0 applies no limit.
- R11: A configuration write that clears moderation enable while coalescing makes the outputs transparent from the edge of the write. The state reads idle one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads all configuration fields at this edge |
| cfg_timer_code | input | 4 | Coalescing timer code, 0 disables |
| cfg_watermark | input | BW+log2(NP) | Summed byte watermark |
| cfg_itr_gap | input | GW | Quiet cycles after each released interrupt |
| cfg_mod_en | input | 1 | Interrupt moderation enable |
| buf_level | input | NP×BW | Bytes held in each port buffer, port p at bits p×BW upward |
| dma_req | input | NP | Per-port DMA request |
| dma_gnt | output | NP | Per-port DMA grant |
| irq_req | input | NP | Per-port interrupt request |
| irq_out | output | NP | Per-port released interrupt |
| stat_state | output | 2 | 0 idle, 1 coalescing, 2 burst |
| stat_cause | output | 2 | Last exit cause: 0 none, 1 watermark, 2 timer |

## Verification
The bench targets the exact length of the timer window for three codes, including one that is clamped. A counter that is off by one, or that keeps running from an earlier period, moves the burst edge and is reported. It makes the watermark and timer expiry arrive in the same cycle, so a design that favours the timer reports the wrong cause. It drives a summed level exactly equal to the watermark, which catches a strict compare. It holds an interrupt request high through the throttle, so a gap that is one cycle short or long changes the release pattern. A moderation switch-off during coalescing exposes a design that keeps gating the ports after it has been disabled.

// File: rtl/dcoal_pkg.sv
package dcoal_pkg;
  localparam int UW = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COAL  = 2'd1,
    ST_BURST = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    CZ_NONE  = 2'd0,
    CZ_WMARK = 2'd1,
    CZ_TIMER = 2'd2
  } cause_e;

  // Timer code to microsecond limit; codes above 12 clamp to the maximum.
  function automatic logic [UW-1:0] code_to_us(input logic [3:0] code);
    logic [UW-1:0] v;
    if (code == 4'd0)       v = '0;
    else if (code == 4'd1)  v = UW'(250);
    else if (code == 4'd2)  v = UW'(500);
    else if (code > 4'd12)  v = UW'(10000);
    else                    v = (UW'(code) - UW'(2)) * UW'(1000);
    return v;
  endfunction
endpackage

// File: rtl/dcoal_timer.sv
module dcoal_timer #(
  parameter int CLK_PER_US = 250,
  parameter int UW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [UW-1:0] limit_us,
  output logic          expire
);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      us_q  <= us_q + UW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  assign expire = run && (pre_q == PRE_LAST) && (us_q == limit_us - UW'(1));
endmodule

// File: rtl/dcoal_level.sv
module dcoal_level #(
  parameter int NP = 4,
  parameter int BW = 16
) (
  input  logic [NP*BW-1:0]          levels,
  input  logic [BW+$clog2(NP)-1:0]  wmark,
  output logic                      all_empty,
  output logic                      wm_hit
);
  localparam int SW = BW + $clog2(NP);

  logic [SW-1:0] total;

  always_comb begin
    total = '0;
    for (int p = 0; p < NP; p++) begin
      total = total + SW'(levels[p*BW +: BW]);
    end
  end

  assign all_empty = (total == '0);
  assign wm_hit    = !all_empty && (total >= wmark);
endmodule

// File: rtl/dcoal_fsm.sv
module dcoal_fsm
  import dcoal_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   all_empty,
  input  logic   wm_hit,
  input  logic   tmr_expire,
  output st_e    state,
  output cause_e cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cause <= CZ_NONE;
    end else if (!en) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wm_hit) begin
            state <= ST_BURST;
            cause <= CZ_WMARK;
          end else if (!all_empty) begin
            state <= ST_COAL;
          end
        end
        ST_COAL: begin
          if (wm_hit) begin
            state <= ST_BURST;
            cause <= CZ_WMARK;
          end else if (tmr_expire) begin
            state <= ST_BURST;
            cause <= CZ_TIMER;
          end
        end
        ST_BURST: begin
          if (all_empty) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcoal_itr.sv
module dcoal_itr #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [GW-1:0] gap,
  output logic          open
);
  logic [GW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       hold_q <= '0;
    else if (fire && gap != '0)       hold_q <= gap;
    else if (hold_q != '0)            hold_q <= hold_q - GW'(1);
  end

  assign open = (hold_q == '0);
endmodule

// File: rtl/dcoal_ctrl.sv
module dcoal_ctrl
  import dcoal_pkg::*;
#(
  parameter int NP = 4,
  parameter int BW = 16,
  parameter int GW = 16,
  parameter int CLK_PER_US = 250
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [3:0]               cfg_timer_code,
  input  logic [BW+$clog2(NP)-1:0] cfg_watermark,
  input  logic [GW-1:0]            cfg_itr_gap,
  input  logic                     cfg_mod_en,
  input  logic [NP*BW-1:0]         buf_level,
  input  logic [NP-1:0]            dma_req,
  output logic [NP-1:0]            dma_gnt,
  input  logic [NP-1:0]            irq_req,
  output logic [NP-1:0]            irq_out,
  output logic [1:0]               stat_state,
  output logic [1:0]               stat_cause
);
  localparam int SW = BW + $clog2(NP);

  logic [3:0]    code_r;
  logic [SW-1:0] wmark_r;
  logic [GW-1:0] itr_gap_r;
  logic          mod_en_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_r    <= '0;
      wmark_r   <= '0;
      itr_gap_r <= '0;
      mod_en_r  <= 1'b0;
    end else if (cfg_we) begin
      code_r    <= cfg_timer_code;
      wmark_r   <= cfg_watermark;
      itr_gap_r <= cfg_itr_gap;
      mod_en_r  <= cfg_mod_en;
    end
  end

  logic          coal_en;
  logic [UW-1:0] limit_us;
  assign coal_en  = (code_r != 4'd0) && mod_en_r;
  assign limit_us = code_to_us(code_r);

  logic   lvl_empty, lvl_wm_hit, tmr_expire, itr_open, in_burst;
  st_e    fsm_state;
  cause_e fsm_cause;

  dcoal_level #(.NP(NP), .BW(BW)) u_level (
    .levels(buf_level), .wmark(wmark_r),
    .all_empty(lvl_empty), .wm_hit(lvl_wm_hit)
  );

  dcoal_timer #(.CLK_PER_US(CLK_PER_US), .UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(coal_en && fsm_state == ST_COAL),
    .limit_us(limit_us), .expire(tmr_expire)
  );

  dcoal_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(coal_en),
    .all_empty(lvl_empty), .wm_hit(lvl_wm_hit), .tmr_expire(tmr_expire),
    .state(fsm_state), .cause(fsm_cause)
  );

  dcoal_itr #(.GW(GW)) u_itr (
    .clk(clk), .rst_n(rst_n), .fire(|irq_out),
    .gap(itr_gap_r), .open(itr_open)
  );

  assign in_burst = (fsm_state == ST_BURST);

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign dma_gnt[p] = coal_en ? (dma_req[p] & in_burst) : dma_req[p];
    assign irq_out[p] = coal_en ? (irq_req[p] & in_burst & itr_open) : irq_req[p];
  end

  assign stat_state = fsm_state;
  assign stat_cause = fsm_cause;
endmodule

// File: rtl/dcoal_ctrl_chk.sv
module dcoal_ctrl_chk #(
  parameter int NP = 4,
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          all_empty,
  input logic          wm_hit,
  input logic [GW-1:0] gap,
  input logic [NP-1:0] dma_req,
  input logic [NP-1:0] dma_gnt,
  input logic [NP-1:0] irq_req,
  input logic [NP-1:0] irq_out,
  input logic [1:0]    stat_state,
  input logic [1:0]    stat_cause
);
  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (dma_gnt == dma_req) && (irq_out == irq_req));

  // R3
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stat_state != 2'd2 |-> (dma_gnt == '0) && (irq_out == '0));

  // R8
  burst_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stat_state == 2'd2 |-> dma_gnt == dma_req);

  // R5
  wm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stat_state != 2'd2 && wm_hit |=> stat_state == 2'd2 && stat_cause == 2'd1);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && stat_state == 2'd2 && all_empty |=> stat_state == 2'd0);

  // R10
  itr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && (|irq_out) && gap != '0 |=> !en || irq_out == '0);

  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state != 2'd3 && stat_cause != 2'd3);
endmodule

bind dcoal_ctrl dcoal_ctrl_chk #(.NP(NP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(coal_en),
  .all_empty(lvl_empty), .wm_hit(lvl_wm_hit), .gap(itr_gap_r),
  .dma_req(dma_req), .dma_gnt(dma_gnt),
  .irq_req(irq_req), .irq_out(irq_out),
  .stat_state(stat_state), .stat_cause(stat_cause)
);

// File: tb/sim_dcoal_ctrl.sv
module sim_dcoal_ctrl;
  localparam int NP = 4;
  localparam int BW = 16;
  localparam int GW = 16;
  localparam int CPU = 2;
  localparam int SW = BW + $clog2(NP);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_timer_code = '0;
  logic [SW-1:0]    cfg_watermark = '0;
  logic [GW-1:0]    cfg_itr_gap = '0;
  logic             cfg_mod_en = 1'b0;
  logic [NP*BW-1:0] buf_level = '0;
  logic [NP-1:0]    dma_req = '0, irq_req = '0;
  logic [NP-1:0]    dma_gnt, irq_out;
  logic [1:0]       stat_state, stat_cause;

  always #2 clk = ~clk;

  dcoal_ctrl #(.NP(NP), .BW(BW), .GW(GW), .CLK_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_timer_code(cfg_timer_code),
    .cfg_watermark(cfg_watermark), .cfg_itr_gap(cfg_itr_gap), .cfg_mod_en(cfg_mod_en),
    .buf_level(buf_level), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .irq_req(irq_req), .irq_out(irq_out),
    .stat_state(stat_state), .stat_cause(stat_cause)
  );

  typedef struct {
    int    cyc;
    int    kind;   // 0 state, 1 cause, 2 grant, 3 irq
    int    exp;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations whose cycle has come and compares.
  always begin
    @(posedge clk);
    #1;
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t it;
      int act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = int'(stat_state);
        1: act = int'(stat_cause);
        2: act = int'(dma_gnt);
        default: act = int'(irq_out);
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                 it.tag, it.kind, cyc, act, it.exp);
      end
    end
  end

  // Driver side: queue an expectation d edges after the current negedge.
  task automatic expect_in(input int d, input int kind, input int val, input string tag);
    exp_t it;
    int i;
    it.cyc = cyc + d; it.kind = kind; it.exp = val; it.tag = tag;
    i = 0;
    while (i < exp_q.size() && exp_q[i].cyc <= it.cyc) i++;
    exp_q.insert(i, it);
  endtask

  task automatic nedge(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_buf(input int p, input int v);
    buf_level[p*BW +: BW] = BW'(v);
  endtask

  task automatic cfg_write(input int code, input int wm, input int gap, input bit men);
    cfg_timer_code = 4'(code);
    cfg_watermark  = SW'(wm);
    cfg_itr_gap    = GW'(gap);
    cfg_mod_en     = men;
    cfg_we         = 1'b1;
    nedge();
    cfg_we         = 1'b0;
  endtask

  initial begin
    nedge(3);
    rst_n = 1'b1;
    // R1 / R2: reset state and transparent outputs
    dma_req = 4'b1010; irq_req = 4'b0101;
    expect_in(1, 0, 0, "R1");
    expect_in(1, 1, 0, "R1");
    expect_in(1, 2, 10, "R2");
    expect_in(1, 3, 5, "R2");
    nedge(2);
    set_buf(0, 5000);
    expect_in(2, 0, 0, "R2");
    expect_in(2, 2, 10, "R2");
    nedge(3);
    set_buf(0, 0); irq_req = '0; dma_req = 4'b1111;
    nedge();

    // Enable: code 1 (250 us), watermark 1000, gap 3
    cfg_timer_code = 4'd1; cfg_watermark = SW'(1000); cfg_itr_gap = GW'(3);
    cfg_mod_en = 1'b1; cfg_we = 1'b1;
    expect_in(1, 2, 0, "R3");
    expect_in(1, 0, 0, "R3");
    nedge();
    cfg_we = 1'b0;

    // Watermark from idle
    set_buf(1, 600); set_buf(2, 500);
    expect_in(1, 0, 2, "R5");
    expect_in(1, 1, 1, "R5");
    expect_in(1, 2, 15, "R8");
    nedge();
    set_buf(1, 0); set_buf(2, 0);
    expect_in(1, 0, 0, "R9");
    nedge();
    // Watermark reached exactly while coalescing
    set_buf(3, 300);
    expect_in(1, 0, 1, "R4");
    nedge(5);
    set_buf(0, 700);
    expect_in(1, 0, 2, "R5");
    nedge();
    set_buf(0, 0); set_buf(3, 0);
    nedge();

    // Timer exit with code 1: 250 us * 2 cycles
    set_buf(0, 100);
    expect_in(1, 0, 1, "R4");
    expect_in(10, 2, 0, "R3");
    expect_in(500, 0, 1, "R6");
    expect_in(501, 0, 2, "R6");
    expect_in(501, 1, 2, "R6");
    expect_in(501, 2, 15, "R8");
    nedge(501);
    // Throttle in burst
    irq_req = 4'b0010;
    expect_in(1, 3, 0, "R10");
    expect_in(2, 3, 0, "R10");
    expect_in(3, 3, 0, "R10");
    expect_in(4, 3, 2, "R10");
    expect_in(5, 3, 0, "R10");
    nedge(6);
    irq_req = '0;
    set_buf(0, 0);
    expect_in(1, 0, 0, "R9");
    expect_in(1, 2, 0, "R3");
    nedge(2);

    // Code 2 (500 us), watermark arriving on the expiry cycle
    cfg_write(2, 1000, 3, 1'b1);
    set_buf(3, 50);
    expect_in(1, 0, 1, "R9");
    expect_in(1000, 0, 1, "R7");
    nedge(1000);
    set_buf(0, 2000);
    expect_in(1, 0, 2, "R7");
    expect_in(1, 1, 1, "R5");
    nedge();
    set_buf(0, 0); set_buf(3, 0);
    nedge(2);

    // Code 13 clamps to 10000 us
    cfg_write(13, 1000, 3, 1'b1);
    set_buf(3, 50);
    expect_in(20000, 0, 1, "R7");
    expect_in(20001, 0, 2, "R7");
    expect_in(20001, 1, 2, "R7");
    nedge(20001);
    set_buf(3, 0);
    expect_in(1, 0, 0, "R9");
    nedge(2);

    // Moderation switched off while coalescing
    cfg_write(1, 1000, 3, 1'b1);
    set_buf(0, 10);
    expect_in(1, 0, 1, "R4");
    nedge(3);
    cfg_timer_code = 4'd1; cfg_mod_en = 1'b0; cfg_we = 1'b1;
    irq_req = 4'b0101;
    expect_in(1, 2, 15, "R11");
    expect_in(1, 3, 5, "R11");
    expect_in(2, 0, 0, "R11");
    nedge();
    cfg_we = 1'b0;
    nedge(5);

    while (exp_q.size() > 0) nedge();
    nedge();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule